// File: doc/BRIEF.md
# PPS-Disciplined Event Timestamp Capture

This block keeps time on a fast local clock in two parts. The first part is a 40-bit count of whole seconds. The second is a 32-bit count of fast clock ticks inside the current second. The seconds value for the coming second is loaded ahead of time through a parallel strobe into a pending register. It takes effect only when the active-low pulse-per-second input falls. That same falling edge restarts the tick count from zero. A consumer that needs only one-second resolution can read the current seconds output on its own.

When the event input is high, the block freezes the current seconds and tick values into a 72-bit record held in a parallel-in serial-out register. It then sends the record out one bit per clock while the receiver holds shift-enable high. A completion flag shows that the whole record has gone out. An event that arrives while a record is still being sent is dropped, and a sticky flag reports the loss. The resolution of a stamp is one fast clock period, so a 10 MHz clock gives 100 ns.

Top module: `pps_event_stamper`

## Requirements
- R1: Outside a PPS strobe cycle, `tick_cnt` rises by exactly one on every clock edge.
- R2: A `sec_load` pulse stores `sec_load_val` as the pending seconds value. `cur_sec` does not change until the next PPS strobe.
- R3: On a PPS strobe, `cur_sec` takes the pending value and `tick_cnt` restarts at 0. After that, `tick_cnt` reads n once n further edges have passed.
- R4: `pps_n` passes through two synchroniser flops, and only its high-to-low transition acts. If `pps_n` is first sampled low at edge k, `cur_sec` changes at edge k+2 and not before. Holding `pps_n` low does not restart the count again.
- R5: A cycle with `event_in` high while not busy captures a 72-bit record. Bits 71:32 hold the seconds value and bits 31:0 hold the tick count of that cycle. `busy` rises on the next edge.
- R6: The record leaves on `ser_out` most significant bit first, with bit 71 presented first. The output advances one bit per edge while `shift_en` is high and holds while `shift_en` is low.
- R7: After the 72nd bit, `busy` falls and `rec_done` stays high until the next accepted event.
- R8: An event in the PPS strobe cycle is stamped with the new seconds value and a tick count of 0.
- R9: An event while `busy` is dropped and sets the sticky `overrun` flag. An `ovr_clr` pulse clears the flag, and a new loss in the same cycle wins over the clear.
- R10: With no PPS, `tick_cnt` saturates at all ones instead of wrapping.
- R11: After reset, `busy`, `rec_done`, `overrun`, `ser_out` and `cur_sec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_load | input | 1 | Strobe that stores the pending seconds value |
| sec_load_val | input | 40 | Seconds value for the next PPS |
| pps_n | input | 1 | Active-low pulse-per-second, asynchronous |
| event_in | input | 1 | Event request, one capture per high cycle |
| shift_en | input | 1 | Receiver ready for the next serial bit |
| ovr_clr | input | 1 | Clears the overrun flag |
| cur_sec | output | 40 | Current whole-seconds value |
| tick_cnt | output | 32 | Ticks since the last PPS |
| ser_out | output | 1 | Serial record bit, valid while busy |
| busy | output | 1 | A record is being sent |
| rec_done | output | 1 | The last record has been fully sent |
| overrun | output | 1 | Sticky flag for a dropped event |

## Verification
The hardest case to reach from the ports is an event that lands exactly in the PPS strobe cycle. That cycle is hidden behind the synchroniser, so the bench lowers `pps_n` at a known falling clock edge and counts two rising edges before it raises `event_in` for one cycle. It then expects a record with the pending seconds value and a zero tick count. Saturation cannot be reached with a 32-bit counter inside the run. A second instance with an 8-bit tick width is therefore left without PPS until its counter tops out. Overrun is reached by holding `shift_en` low, so that a second event finds the register still busy.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int SEC_W_DEF  = 40;
  localparam int TICK_W_DEF = 32;
  localparam int SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    PISO_IDLE  = 2'd0,
    PISO_SHIFT = 2'd1,
    PISO_DONE  = 2'd2
  } piso_state_e;
endpackage

// File: rtl/stamp_rst_sync.sv
module stamp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pps_edge_detect.sv
module pps_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_n,
  output logic pps_stb
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  // synchroniser chain, one flop per stage
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb sync_d[i] = pps_n;
    end else begin : g_next
      always_comb sync_d[i] = sync_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b1;
      else        sync_q[i] <= sync_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[STAGES-1];
  end

  // high for one cycle after a synchronised high-to-low transition
  assign pps_stb = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sec_time_base.sv
module sec_time_base #(
  parameter int SEC_W  = 40,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_load,
  input  logic [SEC_W-1:0]  sec_load_val,
  input  logic              pps_stb,
  output logic [SEC_W-1:0]  cur_sec,
  output logic [TICK_W-1:0] tick_cnt,
  output logic [SEC_W-1:0]  stamp_sec,
  output logic [TICK_W-1:0] stamp_tick
);
  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic [SEC_W-1:0]  pend_q, pend_d;
  logic [SEC_W-1:0]  sec_q,  sec_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              pend_en, sec_en;

  always_comb begin
    pend_en = sec_load;
    pend_d  = sec_load_val;
    sec_en  = pps_stb;
    sec_d   = pend_q;
    if (pps_stb)                tick_d = '0;
    else if (tick_q == TICK_MAX) tick_d = tick_q;
    else                         tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sec_q  <= '0;
      tick_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (sec_en)  sec_q  <= sec_d;
      tick_q <= tick_d;
    end
  end

  // in a strobe cycle the stamp already reflects the new second
  always_comb begin
    stamp_sec  = pps_stb ? pend_q : sec_q;
    stamp_tick = pps_stb ? '0     : tick_q;
  end

  assign cur_sec  = sec_q;
  assign tick_cnt = tick_q;
endmodule

// File: rtl/stamp_piso.sv
module stamp_piso
  import stamp_pkg::*;
#(
  parameter int REC_W = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic [REC_W-1:0] rec_in,
  input  logic             shift_en,
  input  logic             ovr_clr,
  output logic             ser_out,
  output logic             busy,
  output logic             rec_done,
  output logic             overrun
);
  localparam int              CNT_W   = $clog2(REC_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REC_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  piso_state_e      state_q, state_d;
  logic [REC_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic             ovr_q,   ovr_d;
  logic             accept, step, drop;

  always_comb begin
    accept  = event_in && (state_q != PISO_SHIFT);
    drop    = event_in && (state_q == PISO_SHIFT);
    step    = (state_q == PISO_SHIFT) && shift_en;
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = PISO_SHIFT;
      shreg_d = rec_in;
      cnt_d   = CNT_FULL;
    end else if (step) begin
      shreg_d = {shreg_q[REC_W-2:0], 1'b0};
      cnt_d   = cnt_q - 1'b1;
      if (cnt_q == CNT_ONE) state_d = PISO_DONE;
    end
    if (drop)         ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PISO_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept || step) begin
        shreg_q <= shreg_d;
        cnt_q   <= cnt_d;
      end
      ovr_q <= ovr_d;
    end
  end

  assign busy     = (state_q == PISO_SHIFT);
  assign rec_done = (state_q == PISO_DONE);
  assign ser_out  = busy & shreg_q[REC_W-1];
  assign overrun  = ovr_q;
endmodule

// File: rtl/pps_event_stamper.sv
module pps_event_stamper
  import stamp_pkg::*;
#(
  parameter int SEC_W       = SEC_W_DEF,
  parameter int TICK_W      = TICK_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_load,
  input  logic [SEC_W-1:0]  sec_load_val,
  input  logic              pps_n,
  input  logic              event_in,
  input  logic              shift_en,
  input  logic              ovr_clr,
  output logic [SEC_W-1:0]  cur_sec,
  output logic [TICK_W-1:0] tick_cnt,
  output logic              ser_out,
  output logic              busy,
  output logic              rec_done,
  output logic              overrun
);
  localparam int REC_W = SEC_W + TICK_W;

  logic              rst_n_s;
  logic              pps_stb;
  logic [SEC_W-1:0]  stamp_sec;
  logic [TICK_W-1:0] stamp_tick;

  stamp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pps_edge_detect #(.STAGES(SYNC_STAGES)) u_pps (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pps_n   (pps_n),
    .pps_stb (pps_stb)
  );

  sec_time_base #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .sec_load     (sec_load),
    .sec_load_val (sec_load_val),
    .pps_stb      (pps_stb),
    .cur_sec      (cur_sec),
    .tick_cnt     (tick_cnt),
    .stamp_sec    (stamp_sec),
    .stamp_tick   (stamp_tick)
  );

  stamp_piso #(.REC_W(REC_W)) u_piso (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .event_in (event_in),
    .rec_in   ({stamp_sec, stamp_tick}),
    .shift_en (shift_en),
    .ovr_clr  (ovr_clr),
    .ser_out  (ser_out),
    .busy     (busy),
    .rec_done (rec_done),
    .overrun  (overrun)
  );
endmodule

// File: rtl/stamp_checks.sv
module stamp_checks #(
  parameter int SEC_W  = 40,
  parameter int TICK_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pps_stb,
  input logic [SEC_W-1:0]  cur_sec,
  input logic [TICK_W-1:0] tick_cnt,
  input logic              event_in,
  input logic              shift_en,
  input logic              ser_out,
  input logic              busy,
  input logic              rec_done,
  input logic              overrun,
  input logic              ovr_clr
);
  localparam logic [TICK_W-1:0] TMAX = '1;

  p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pps_stb && tick_cnt != TMAX) |=> tick_cnt == $past(tick_cnt) + 1'b1);

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pps_stb |=> $stable(cur_sec));

  p_tick_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pps_stb |=> tick_cnt == '0);

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pps_stb |=> !pps_stb);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && !busy) |=> busy && !rec_done);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_en && !event_in) |=> busy && $stable(ser_out));

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rec_done));

  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && busy) |=> overrun);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pps_stb && tick_cnt == TMAX) |=> tick_cnt == TMAX);
endmodule

bind pps_event_stamper stamp_checks #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .pps_stb  (pps_stb),
  .cur_sec  (cur_sec),
  .tick_cnt (tick_cnt),
  .event_in (event_in),
  .shift_en (shift_en),
  .ser_out  (ser_out),
  .busy     (busy),
  .rec_done (rec_done),
  .overrun  (overrun),
  .ovr_clr  (ovr_clr)
);

// File: tb/pps_event_stamper_test.sv
module pps_event_stamper_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 40;
  localparam int TW = 32;
  localparam int RW = SW + TW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sec_load;
  logic [SW-1:0] sec_load_val;
  logic          pps_n;
  logic          event_in;
  logic          shift_en;
  logic          ovr_clr;
  logic [SW-1:0] cur_sec;
  logic [TW-1:0] tick_cnt;
  logic          ser_out, busy, rec_done, overrun;

  logic [SW-1:0] s_sec;
  logic [7:0]    s_tick;
  logic          s_ser, s_busy, s_done, s_ovr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [RW-1:0] exp_q[$];
  logic [RW-1:0] mon_rec;
  int            mon_bits = 0;
  int            rec_seen = 0;
  logic [SW-1:0] model_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_event_stamper uut (
    .clk(clk), .rst_n(rst_n), .sec_load(sec_load), .sec_load_val(sec_load_val),
    .pps_n(pps_n), .event_in(event_in), .shift_en(shift_en), .ovr_clr(ovr_clr),
    .cur_sec(cur_sec), .tick_cnt(tick_cnt), .ser_out(ser_out), .busy(busy),
    .rec_done(rec_done), .overrun(overrun)
  );

  // narrow-counter copy used only to reach saturation
  pps_event_stamper #(.TICK_W(8)) uut_sat (
    .clk(clk), .rst_n(rst_n), .sec_load(1'b0), .sec_load_val('0),
    .pps_n(1'b1), .event_in(1'b0), .shift_en(1'b0), .ovr_clr(1'b0),
    .cur_sec(s_sec), .tick_cnt(s_tick), .ser_out(s_ser), .busy(s_busy),
    .rec_done(s_done), .overrun(s_ovr)
  );

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: collect bits as they leave and compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n && busy && shift_en) begin
      mon_rec = {mon_rec[RW-2:0], ser_out};
      mon_bits++;
      if (mon_bits == RW) begin
        mon_bits = 0;
        rec_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected record", mon_rec, '0);
        end else begin
          logic [RW-1:0] e;
          e = exp_q.pop_front();
          check(mon_rec == e, "R5/R6 record content and order", mon_rec, e);
        end
      end
    end
  end

  task automatic load_sec(input logic [SW-1:0] v);
    sec_load = 1'b1; sec_load_val = v;
    @(negedge clk);
    sec_load = 1'b0;
    model_pend = v;
  endtask

  // driver: called at a negedge, stamps the values visible in this cycle
  task automatic fire_event();
    exp_q.push_back({cur_sec, tick_cnt});
    event_in = 1'b1;
    @(negedge clk);
    event_in = 1'b0;
  endtask

  task automatic pps_pulse();
    pps_n = 1'b0;
    repeat (4) @(negedge clk);
    pps_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(input bit stutter);
    int guard = 0;
    while (busy && guard < 400) begin
      shift_en = stutter ? ~shift_en : 1'b1;
      @(negedge clk);
      guard++;
    end
    shift_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sec_load = 1'b0; sec_load_val = '0; pps_n = 1'b1;
    event_in = 1'b0; shift_en = 1'b0; ovr_clr = 1'b0; model_pend = '0;
    mon_rec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check({busy, rec_done, overrun, ser_out} == 4'b0, "R11 flags after reset",
          RW'({busy, rec_done, overrun, ser_out}), '0);
    check(cur_sec == '0, "R11 seconds after reset", RW'(cur_sec), '0);

    // R2 pending value does not show before PPS
    load_sec(40'h12_3456_789A);
    repeat (5) @(negedge clk);
    check(cur_sec == '0, "R2 seconds held before PPS", RW'(cur_sec), '0);

    // R4 latency and R3 restart; pps_n held low afterwards
    pps_n = 1'b0;
    @(negedge clk);
    check(cur_sec == '0, "R4 no change after first edge", RW'(cur_sec), '0);
    @(negedge clk);
    check(cur_sec == '0, "R4 no change after second edge", RW'(cur_sec), '0);
    @(negedge clk);
    check(cur_sec == model_pend, "R3 seconds take pending value", RW'(cur_sec), RW'(model_pend));
    check(tick_cnt == '0, "R3 tick restarts at zero", RW'(tick_cnt), '0);
    repeat (5) @(negedge clk);
    check(tick_cnt == 32'd5, "R1 tick counts up by one", RW'(tick_cnt), RW'(5));
    repeat (15) @(negedge clk);
    check(tick_cnt == 32'd20, "R4 held low does not restart", RW'(tick_cnt), RW'(20));
    pps_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tick_cnt == 32'd24, "R4 rising edge has no effect", RW'(tick_cnt), RW'(24));

    // R5 R6 R7 plain events with continuous shifting
    fire_event();
    drain(1'b0);
    @(negedge clk);
    check(rec_done && !busy, "R7 done after last bit", RW'({rec_done, busy}), RW'(2'b10));
    load_sec(40'hA5_F00F_0C3C);
    pps_pulse();
    repeat (17) @(negedge clk);
    fire_event();
    check(!rec_done, "R7 done cleared by new capture", RW'(rec_done), '0);
    drain(1'b1);  // R6 stalls between bits

    // R8 event in the strobe cycle
    load_sec(40'hFF_0000_0001);
    repeat (3) @(negedge clk);
    pps_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back({model_pend, 32'd0});
    event_in = 1'b1;
    @(negedge clk);
    event_in = 1'b0;
    pps_n = 1'b1;
    drain(1'b0);

    // R9 drop while busy
    repeat (9) @(negedge clk);
    fire_event();
    repeat (3) @(negedge clk);
    event_in = 1'b1;   // dropped, not pushed
    @(negedge clk);
    event_in = 1'b0;
    check(overrun, "R9 overrun set on drop", RW'(overrun), RW'(1));
    repeat (4) @(negedge clk);
    check(overrun, "R9 overrun sticky", RW'(overrun), RW'(1));
    drain(1'b0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0 && rec_seen == 4, "R9 dropped event sent nothing",
          RW'(rec_seen), RW'(4));
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check(!overrun, "R9 clear input", RW'(overrun), '0);

    // R9 set wins over clear in the same cycle
    fire_event();
    ovr_clr = 1'b1;
    event_in = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    event_in = 1'b0;
    check(overrun, "R9 set beats clear", RW'(overrun), RW'(1));
    drain(1'b0);
    repeat (2) @(negedge clk);
    check(rec_seen == 5, "R5 record count", RW'(rec_seen), RW'(5));

    // R10 saturation on the narrow copy
    while (s_tick != 8'hFF && n_checks < 1000000) begin
      if ($time > 64'd100000) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(s_tick == 8'hFF, "R10 tick saturates", RW'(s_tick), RW'(8'hFF));
    repeat (3) @(negedge clk);
    check(s_tick == 8'hFF, "R10 tick stays saturated", RW'(s_tick), RW'(8'hFF));

    finish_run();
  end
endmodule